// File: doc/BRIEF.md
# Paged Multi-Channel Register Bank Selector

This block is the register-access front end of a device that has eight identical per-channel register banks and two shared banks, each shared bank serving one group of four channels. A host reaches it over a byte-wide register bus made of an address, write data, a write strobe, a read strobe and a registered read-data return. The top of the address space, 0xEF to 0xFF, is a global window that is always mapped. It holds a channel-select mask, a page-control register, a spare scratch register and fixed identification values.

Every address below the window is paged. Bit 0 of the page-control register chooses between the channel banks and the shared banks. In channel mode, the channel mask picks the target banks. A broadcast bit can send each write to all channel banks at once, while reads still come from the masked channel. In shared mode, two page-control bits pick one or both shared banks. Bank storage is modelled as plain byte arrays of `BANK_DEPTH` entries.

Top module: `paged_bank_selector`

## Requirements
- R1: Addresses 0xEF through 0xFF reach the global registers whatever the page setting, and a write to any of them never changes bank contents.
- R2: Register 0xFC is a read/write channel mask with reset value 0x00, in which bit n flags channel n for n = 0 to 7.
- R3: When 0xFF bit 0 is 1, a paged write goes to every channel flagged in 0xFC. A paged read returns the lowest-numbered flagged channel, or 0x00 when none is flagged.
- R4: When 0xFF bit 0 is 0, 0xFF bit 4 selects the shared bank of channels 0-3 and bit 5 selects the shared bank of channels 4-7, and 0xFF resets to 0x10. With both bits set, a write goes to both banks and a read returns the first bank. With neither set, the write is dropped and the read returns 0x00.
- R5: With 0xFF bits 1 and 0 both 1 (broadcast), a paged write goes to all eight channel banks. A paged read returns the lowest-numbered channel flagged in 0xFC, or 0x00 when none is flagged.
- R6: 0xFF bit 1 has no effect while 0xFF bit 0 is 0.
- R7: The identification registers read 0xEF=0x0C, 0xF0=0x00, 0xF1=0x42, 0xF3=0x00 and 0xFE=0x03, and writes to them change nothing.
- R8: Register 0xFD (reset 0x00) and all eight bits of 0xFF read back the last value written. The spare bits 7:6 and 3:2 of 0xFF do not alter routing.
- R9: Global-window addresses with no register (0xF2, 0xF4-0xFB) read 0x00 and ignore writes.
- R10: A paged address at or above `BANK_DEPTH` reads 0x00, and writes to it are dropped.
- R11: Read data is registered. It takes its new value on the clock edge that samples the read strobe and holds it until the next read. A read in the same cycle as a write returns the value from before the write.
- R12: Synchronous reset returns every register and every bank byte to its default, with bank bytes set to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |

## Verification
The hardest case to reach from the ports is proving that a write landed in a bank other than the one currently being read. That bank can only be observed after the page or mask registers have been reprogrammed. Each routing scenario therefore writes under one page setting and then switches 0xFF or 0xFC before reading back. Examples are a multi-flag write checked channel by channel, a broadcast write read from distant channels, and a dual-shared write read from each shared bank alone. Distinct data values for each scenario keep a stale byte from passing as a correct one.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [7:0] GLB_BASE  = 8'hEF;
  localparam logic [7:0] A_CHMASK  = 8'hFC;
  localparam logic [7:0] A_SPARE   = 8'hFD;
  localparam logic [7:0] A_PAGE    = 8'hFF;
  localparam logic [7:0] PAGE_RST  = 8'h10;

  // page-control bit positions
  localparam int PG_CHAN  = 0;
  localparam int PG_BCAST = 1;
  localparam int PG_SH0   = 4;

  function automatic logic is_global(input logic [7:0] a);
    return a >= GLB_BASE;
  endfunction

  // returns {hit, value} for the fixed identification registers
  function automatic logic [8:0] id_lookup(input logic [7:0] a);
    case (a)
      8'hEF:   return {1'b1, 8'h0C};
      8'hF0:   return {1'b1, 8'h00};
      8'hF1:   return {1'b1, 8'h42};
      8'hF3:   return {1'b1, 8'h00};
      8'hFE:   return {1'b1, 8'h03};
      default: return {1'b0, 8'h00};
    endcase
  endfunction
endpackage

// File: rtl/bsel_global_regs.sv
module bsel_global_regs
  import bsel_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              wr,
  output logic [NUM_CH-1:0] ch_mask,
  output logic [7:0]        page,
  output logic [7:0]        glb_rdata
);
  logic [7:0] mask_q, spare_q, page_q;
  logic       wr_mask, wr_spare, wr_page;
  logic [8:0] id_hit;

  assign wr_mask  = wr && (addr == A_CHMASK);
  assign wr_spare = wr && (addr == A_SPARE);
  assign wr_page  = wr && (addr == A_PAGE);
  assign id_hit   = id_lookup(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      spare_q <= '0;
      page_q  <= PAGE_RST;
    end else begin
      if (wr_mask)  mask_q  <= wdata;
      if (wr_spare) spare_q <= wdata;
      if (wr_page)  page_q  <= wdata;
    end
  end

  always_comb begin
    glb_rdata = 8'h00;
    if (id_hit[8])              glb_rdata = id_hit[7:0];
    else if (addr == A_CHMASK)  glb_rdata = mask_q;
    else if (addr == A_SPARE)   glb_rdata = spare_q;
    else if (addr == A_PAGE)    glb_rdata = page_q;
  end

  assign ch_mask = mask_q[NUM_CH-1:0];
  assign page    = page_q;

  assert_reset_vals_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == 8'h00 && page_q == PAGE_RST && spare_q == 8'h00));
  assert_id_write_inert_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && id_hit[8]) |=> ($stable(mask_q) && $stable(page_q) && $stable(spare_q)));
  assert_undef_write_inert_R9: assert property (@(posedge clk) disable iff (rst)
    (wr && is_global(addr) && !id_hit[8] && addr != A_CHMASK && addr != A_SPARE
     && addr != A_PAGE) |=> ($stable(mask_q) && $stable(page_q) && $stable(spare_q)));
endmodule

// File: rtl/bsel_route.sv
module bsel_route
  import bsel_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int NUM_SH    = 2,
  parameter int CH_IDX_W  = $clog2(NUM_CH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic                paged_ok,
  input  logic [NUM_CH-1:0]   ch_mask,
  input  logic [7:0]          page,
  output logic [NUM_CH-1:0]   ch_we,
  output logic [NUM_SH-1:0]   sh_we,
  output logic                rd_chan,
  output logic                rd_hit,
  output logic [CH_IDX_W-1:0] rd_idx
);
  logic              chan_mode, bcast;
  logic [NUM_SH-1:0] sh_sel;

  function automatic logic [CH_IDX_W:0] lowest_ch(input logic [NUM_CH-1:0] v);
    logic [CH_IDX_W:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, CH_IDX_W'(i)};
    return r;
  endfunction

  function automatic logic [CH_IDX_W:0] lowest_sh(input logic [NUM_SH-1:0] v);
    logic [CH_IDX_W:0] r;
    r = '0;
    for (int i = NUM_SH - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, CH_IDX_W'(i)};
    return r;
  endfunction

  assign chan_mode = page[PG_CHAN];
  assign bcast     = chan_mode && page[PG_BCAST];
  assign sh_sel    = page[PG_SH0 +: NUM_SH];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_we
      assign ch_we[c] = wr && paged_ok && chan_mode && (bcast || ch_mask[c]);
    end
    for (genvar s = 0; s < NUM_SH; s++) begin : g_sh_we
      assign sh_we[s] = wr && paged_ok && !chan_mode && sh_sel[s];
    end
  endgenerate

  logic [CH_IDX_W:0] pick;
  assign pick    = chan_mode ? lowest_ch(ch_mask) : lowest_sh(sh_sel);
  assign rd_chan = chan_mode;
  assign rd_hit  = pick[CH_IDX_W];
  assign rd_idx  = pick[CH_IDX_W-1:0];

  assert_shared_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    page[PG_CHAN] |-> (sh_we == '0));
  assert_bcast_all_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && paged_ok && page[PG_CHAN] && page[PG_BCAST]) |-> (&ch_we));
  assert_bcast_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    !page[PG_CHAN] |-> (ch_we == '0));
  assert_shared_both_R4: assert property (@(posedge clk) disable iff (rst)
    (wr && paged_ok && !page[PG_CHAN]) |-> (sh_we == page[PG_SH0 +: NUM_SH]));
endmodule

// File: rtl/bsel_bank.sv
module bsel_bank #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/paged_bank_selector.sv
module paged_bank_selector
  import bsel_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int CH_PER_SH  = 4,
  parameter int BANK_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_wr,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata
);
  localparam int NUM_SH   = NUM_CH / CH_PER_SH;
  localparam int IDX_W    = $clog2(BANK_DEPTH);
  localparam int CH_IDX_W = $clog2(NUM_CH);

  logic              glb_hit, paged_ok;
  logic [NUM_CH-1:0] ch_mask, ch_we;
  logic [NUM_SH-1:0] sh_we;
  logic [7:0]        page, glb_rdata, paged_rdata, rdata_q;
  logic              rd_chan, rd_hit;
  logic [CH_IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0]  bidx;
  logic [7:0]        ch_rd [NUM_CH];
  logic [7:0]        sh_rd [NUM_SH];

  assign glb_hit  = is_global(reg_addr);
  assign paged_ok = !glb_hit && (reg_addr < 8'(BANK_DEPTH));
  assign bidx     = reg_addr[IDX_W-1:0];

  bsel_global_regs #(.NUM_CH(NUM_CH)) u_glb (
    .clk(clk), .rst(rst), .addr(reg_addr), .wdata(reg_wdata), .wr(reg_wr),
    .ch_mask(ch_mask), .page(page), .glb_rdata(glb_rdata)
  );

  bsel_route #(.NUM_CH(NUM_CH), .NUM_SH(NUM_SH), .CH_IDX_W(CH_IDX_W)) u_route (
    .clk(clk), .rst(rst), .wr(reg_wr), .paged_ok(paged_ok), .ch_mask(ch_mask),
    .page(page), .ch_we(ch_we), .sh_we(sh_we), .rd_chan(rd_chan),
    .rd_hit(rd_hit), .rd_idx(rd_idx)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_bank
      bsel_bank #(.DEPTH(BANK_DEPTH), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .we(ch_we[c]), .idx(bidx), .wdata(reg_wdata),
        .rdata(ch_rd[c])
      );
    end
    for (genvar s = 0; s < NUM_SH; s++) begin : g_sh_bank
      bsel_bank #(.DEPTH(BANK_DEPTH), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .we(sh_we[s]), .idx(bidx), .wdata(reg_wdata),
        .rdata(sh_rd[s])
      );
    end
  endgenerate

  always_comb begin
    paged_rdata = 8'h00;
    if (paged_ok && rd_hit)
      paged_rdata = rd_chan ? ch_rd[rd_idx] : sh_rd[rd_idx[$clog2(NUM_SH+1)-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= 8'h00;
    else if (reg_rd) rdata_q <= glb_hit ? glb_rdata : paged_rdata;
  end

  assign reg_rdata = rdata_q;

  assert_global_no_bank_R1: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && glb_hit) |-> (ch_we == '0 && sh_we == '0));
  assert_range_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !glb_hit && reg_addr >= 8'(BANK_DEPTH)) |-> (ch_we == '0 && sh_we == '0));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
  assert_rdata_reset_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reg_rdata == 8'h00));
endmodule

// File: tb/test_paged_bank_selector.sv
module test_paged_bank_selector;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  paged_bank_selector i_paged_bank_selector (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    checks++;
    if (reg_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    checks++;
    if (reg_rdata !== 8'h00) begin
      errors++; $display("FAIL R12 rdata after reset: got %h expected 00", reg_rdata);
    end
    expect_rd(8'hFC, 8'h00, "R2");
    expect_rd(8'hFF, 8'h10, "R4");
    expect_rd(8'hFD, 8'h00, "R8");
  endtask

  task automatic t_ids();
    expect_rd(8'hEF, 8'h0C, "R7");
    expect_rd(8'hF0, 8'h00, "R7");
    expect_rd(8'hF1, 8'h42, "R7");
    expect_rd(8'hF3, 8'h00, "R7");
    expect_rd(8'hFE, 8'h03, "R7");
    wr(8'hF1, 8'hFF);
    wr(8'hFE, 8'h55);
    expect_rd(8'hF1, 8'h42, "R7");
    expect_rd(8'hFE, 8'h03, "R7");
    expect_rd(8'hFF, 8'h10, "R7");
  endtask

  task automatic t_undefined();
    wr(8'hF2, 8'hAB);
    wr(8'hF8, 8'hCD);
    expect_rd(8'hF2, 8'h00, "R9");
    expect_rd(8'hF8, 8'h00, "R9");
    expect_rd(8'hFC, 8'h00, "R9");
  endtask

  task automatic t_shared();
    wr(8'h05, 8'hA1);                 // shared bank 0 (reset page)
    expect_rd(8'h05, 8'hA1, "R4");
    wr(8'hFF, 8'h20);
    expect_rd(8'h05, 8'h00, "R4");
    wr(8'h05, 8'hB2);
    expect_rd(8'h05, 8'hB2, "R4");
    wr(8'hFF, 8'h30);
    expect_rd(8'h05, 8'hA1, "R4");    // both: reads first bank
    wr(8'h06, 8'hC3);
    wr(8'hFF, 8'h10);
    expect_rd(8'h06, 8'hC3, "R4");
    wr(8'hFF, 8'h20);
    expect_rd(8'h06, 8'hC3, "R4");
    wr(8'hFF, 8'h00);
    wr(8'h07, 8'h11);
    expect_rd(8'h07, 8'h00, "R4");
    wr(8'hFF, 8'h10);
    expect_rd(8'h07, 8'h00, "R4");
    wr(8'hFF, 8'h20);
    expect_rd(8'h07, 8'h00, "R4");
  endtask

  task automatic t_channels();
    wr(8'hFF, 8'h01);
    wr(8'hFC, 8'h04);
    expect_rd(8'hFC, 8'h04, "R2");
    wr(8'h03, 8'h44);
    expect_rd(8'h03, 8'h44, "R3");
    wr(8'hFC, 8'h08);
    expect_rd(8'h03, 8'h00, "R3");
    wr(8'hFC, 8'h0C);
    wr(8'h09, 8'h55);
    wr(8'hFC, 8'h08);
    expect_rd(8'h09, 8'h55, "R3");
    wr(8'h0A, 8'h66);
    wr(8'hFC, 8'h04);
    wr(8'h0A, 8'h77);
    wr(8'hFC, 8'h0C);
    expect_rd(8'h0A, 8'h77, "R3");    // lowest flagged is channel 2
    wr(8'hFC, 8'h00);
    expect_rd(8'h0A, 8'h00, "R3");
    expect_rd(8'hFF, 8'h01, "R1");
    wr(8'hFF, 8'h10);
    expect_rd(8'h03, 8'h00, "R3");    // shared 0 untouched
  endtask

  task automatic t_broadcast();
    wr(8'hFF, 8'h03);
    wr(8'hFC, 8'h01);
    wr(8'h0B, 8'h99);
    wr(8'hFC, 8'h80);
    expect_rd(8'h0B, 8'h99, "R5");
    wr(8'hFC, 8'h10);
    expect_rd(8'h0B, 8'h99, "R5");
    wr(8'hFC, 8'h00);
    expect_rd(8'h0B, 8'h00, "R5");
    wr(8'hFF, 8'h12);                 // broadcast bit in shared mode
    wr(8'h0C, 8'h5A);
    expect_rd(8'h0C, 8'h5A, "R6");
    wr(8'hFF, 8'h01);
    wr(8'hFC, 8'h01);
    expect_rd(8'h0C, 8'h00, "R6");
    wr(8'hFC, 8'h80);
    expect_rd(8'h0C, 8'h00, "R6");
  endtask

  task automatic t_spare();
    wr(8'hFD, 8'hA5);
    expect_rd(8'hFD, 8'hA5, "R8");
    wr(8'hFF, 8'hDC);
    expect_rd(8'hFF, 8'hDC, "R8");
    expect_rd(8'h05, 8'hA1, "R8");    // still shared bank 0
    wr(8'hFF, 8'h10);
  endtask

  task automatic t_range();
    wr(8'h1F, 8'h3C);
    wr(8'h20, 8'h77);
    expect_rd(8'h1F, 8'h3C, "R10");
    expect_rd(8'h20, 8'h00, "R10");
    expect_rd(8'h00, 8'h00, "R10");   // no aliasing of 0x20 onto 0x00
  endtask

  task automatic t_read_timing();
    expect_rd(8'h05, 8'hA1, "R11");
    repeat (3) @(negedge clk);
    checks++;
    if (reg_rdata !== 8'hA1) begin
      errors++; $display("FAIL R11 hold: got %h expected A1", reg_rdata);
    end
    @(negedge clk);
    reg_addr = 8'h05; reg_wdata = 8'hE7; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    checks++;
    if (reg_rdata !== 8'hA1) begin
      errors++; $display("FAIL R11 read-during-write: got %h expected A1", reg_rdata);
    end
    expect_rd(8'h05, 8'hE7, "R11");
  endtask

  task automatic t_reset_clears();
    do_reset();
    expect_rd(8'hFF, 8'h10, "R12");
    expect_rd(8'hFC, 8'h00, "R12");
    expect_rd(8'hFD, 8'h00, "R12");
    expect_rd(8'h05, 8'h00, "R12");
    wr(8'hFF, 8'h01);
    wr(8'hFC, 8'h04);
    expect_rd(8'h03, 8'h00, "R12");
  endtask

  initial begin
    rst = 1'b1; reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_ids();
    t_undefined();
    t_shared();
    t_channels();
    t_broadcast();
    t_spare();
    t_range();
    t_read_timing();
    t_reset_clears();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule